// File: doc/BRIEF.md
# Pin Function Multiplexer with Low-Power State

This block is the register-mapped controller for a bank of 32 general-purpose pins. Software uses a small synchronous bus to choose, for each pin, a direction, an output level (through separate set and clear strobes) and one of four alternate functions. The block drives per-pin output level, output-enable and 2-bit function-select signals toward the pad ring and the peripheral mux. It also returns the level seen on each pad.

Ahead of a low-power period, software loads a sleep level and a sleep direction for every pin. A one-cycle sleep-entry strobe then copies both into the live output and direction registers in a single step, so every pin takes its sleep state at the same time. A sleep-exit strobe, like reset, sets a hold flag. While the hold flag is set, the input receivers stay off. It stays set until software writes a one to it.

A build-time mask inverts the meaning of the direction bit on selected pins, which lets pads with reversed direction polarity share the same register view.

Top module: `gpio_pinmux_ctl`

## Requirements
- R1: After reset the output register is 0, the direction register equals the inversion mask so that every pin_oe bit is 0, all function fields and both sleep registers are 0, and the hold flag is 1.
- R2: A bus access is a cycle with req high. When we is also high, the access is a write. When we is low, it is a read, and rdata shows the value one clock later and holds it until the next read. Word addresses: 0 pad level (read only), 1 direction, 2 set strobe, 3 clear strobe, 4 function pins 0-15, 5 function pins 16-31, 6 sleep level, 7 sleep direction, 8 control (bit 0 = hold), 9 output register (read only). Reads of addresses 2, 3 and 10-15 return 0.
- R3: Writing to address 2 sets the output bit of every pin whose wdata bit is 1, and leaves the other output bits unchanged.
- R4: Writing to address 3 clears the output bit of every pin whose wdata bit is 1, and leaves the other output bits unchanged.
- R5: The function of pin p is the 2-bit field at bits 2*(p mod 16)+1 : 2*(p mod 16) of address 4 for p < 16, or of address 5 for p >= 16. It appears on pin_func[2p+1:2p] in the cycle after the write.
- R6: pin_oe[p] is the direction bit of pin p XOR bit p of the inversion mask (default 0x0000F000). On inverted pins, a direction bit of 0 makes the pin an output.
- R7: In the cycle after sleep_enter, the output register equals the sleep level register and the direction register equals the sleep direction register. On those two registers, sleep_enter takes priority over a bus write in the same cycle.
- R8: sleep_exit sets the hold flag. Writing to address 8 with wdata bit 0 set clears it. When both happen in the same cycle, sleep_exit takes priority.
- R9: A read of address 0 returns pad_in while the hold flag is clear, and 0 while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus access strobe |
| we | input | 1 | Write when high, read when low |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sleep_enter | input | 1 | One-cycle strobe that applies the sleep state |
| sleep_exit | input | 1 | One-cycle strobe that re-arms the hold flag |
| pad_in | input | 32 | Levels seen at the pads |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin |
| pin_func | output | 64 | 2-bit function select per pin |

## Verification
The properties assume that sleep_enter and sleep_exit are synchronous one-cycle strobes. They also assume that addr, we and wdata are stable at the sampling edge whenever req is high. The register-effect checks are conditioned on sleep_enter being low, because that strobe takes over the output and direction registers. The stimulus changes every input only on the falling clock edge. It puts sleep and bus writes in the same cycle on purpose to reach the priority cases, and its random phase keeps addresses inside the 4-bit space, including unmapped words.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  localparam int PINS    = 32;
  localparam int ADDR_W  = 4;
  localparam int FSEL_W  = 2;
  localparam int PER_REG = PINS / FSEL_W;
  localparam int NFREG   = (PINS * FSEL_W) / PINS;

  typedef enum logic [ADDR_W-1:0] {
    A_LEVEL   = 4'd0,
    A_DIR     = 4'd1,
    A_SET     = 4'd2,
    A_CLR     = 4'd3,
    A_FUNC_LO = 4'd4,
    A_FUNC_HI = 4'd5,
    A_SLP_LVL = 4'd6,
    A_SLP_DIR = 4'd7,
    A_CTRL    = 4'd8,
    A_OUT     = 4'd9
  } addr_e;

  // bits written as one become one, others keep their value
  function automatic logic [PINS-1:0] apply_set(input logic [PINS-1:0] cur,
                                                input logic [PINS-1:0] m);
    return cur | m;
  endfunction

  // bits written as one become zero, others keep their value
  function automatic logic [PINS-1:0] apply_clr(input logic [PINS-1:0] cur,
                                                input logic [PINS-1:0] m);
    return cur & ~m;
  endfunction

  // which function register holds a pin, and where its field starts
  function automatic int freg_of(input int pin);
    return pin / PER_REG;
  endfunction

  function automatic int fbit_of(input int pin);
    return FSEL_W * (pin % PER_REG);
  endfunction

  function automatic logic addr_is(input logic [ADDR_W-1:0] a, input addr_e e);
    return a == ADDR_W'(e);
  endfunction
endpackage

// File: rtl/gpm_regfile.sv
module gpm_regfile
  import gpm_pkg::*;
#(
  parameter logic [PINS-1:0] DIR_INV = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [PINS-1:0]         wdata,
  input  logic                    sleep_enter,
  input  logic                    sleep_exit,
  output logic [PINS-1:0]         out_q,
  output logic [PINS-1:0]         dir_q,
  output logic [PINS*FSEL_W-1:0]  func_q,
  output logic [PINS-1:0]         slp_lvl_q,
  output logic [PINS-1:0]         slp_dir_q,
  output logic                    hold_q
);
  logic set_hit, clr_hit, dir_hit, slvl_hit, sdir_hit, ctrl_hit, hold_clr;

  assign set_hit  = wr_en && addr_is(addr, A_SET);
  assign clr_hit  = wr_en && addr_is(addr, A_CLR);
  assign dir_hit  = wr_en && addr_is(addr, A_DIR);
  assign slvl_hit = wr_en && addr_is(addr, A_SLP_LVL);
  assign sdir_hit = wr_en && addr_is(addr, A_SLP_DIR);
  assign ctrl_hit = wr_en && addr_is(addr, A_CTRL);
  assign hold_clr = ctrl_hit && wdata[0];

  // output register: sleep entry wins over set/clear strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           out_q <= '0;
    else if (sleep_enter) out_q <= slp_lvl_q;
    else if (set_hit)     out_q <= apply_set(out_q, wdata);
    else if (clr_hit)     out_q <= apply_clr(out_q, wdata);
  end

  // direction register resets to the inversion mask: all pins inputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dir_q <= DIR_INV;
    else if (sleep_enter) dir_q <= slp_dir_q;
    else if (dir_hit)     dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_lvl_q <= '0;
      slp_dir_q <= '0;
    end else begin
      if (slvl_hit) slp_lvl_q <= wdata;
      if (sdir_hit) slp_dir_q <= wdata;
    end
  end

  // hold flag: sleep exit re-arms, write-one clears, exit wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= 1'b1;
    else if (sleep_exit) hold_q <= 1'b1;
    else if (hold_clr)   hold_q <= 1'b0;
  end

  // one storage word per function register
  for (genvar k = 0; k < NFREG; k++) begin : g_freg
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(int'(A_FUNC_LO) + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   func_q[k*PINS +: PINS] <= '0;
      else if (hit) func_q[k*PINS +: PINS] <= wdata;
    end
  end
endmodule

// File: rtl/gpm_pinmap.sv
module gpm_pinmap
  import gpm_pkg::*;
#(
  parameter logic [PINS-1:0] DIR_INV = '0
) (
  input  logic [PINS-1:0]         out_q,
  input  logic [PINS-1:0]         dir_q,
  input  logic [PINS*FSEL_W-1:0]  func_q,
  input  logic [PINS-1:0]         pad_in,
  input  logic                    hold_q,
  output logic [PINS-1:0]         pin_out,
  output logic [PINS-1:0]         pin_oe,
  output logic [PINS*FSEL_W-1:0]  pin_func,
  output logic [PINS-1:0]         level
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    localparam int REG = p / PER_REG;
    localparam int BIT = FSEL_W * (p % PER_REG);
    assign pin_out[p] = out_q[p];
    assign pin_oe[p]  = dir_q[p] ^ DIR_INV[p];
    assign pin_func[p*FSEL_W +: FSEL_W] = func_q[REG*PINS + BIT +: FSEL_W];
    // receivers off while the hold flag is set
    assign level[p]   = pad_in[p] & ~hold_q;
  end
endmodule

// File: rtl/gpm_rdmux.sv
module gpm_rdmux
  import gpm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [PINS-1:0]         level,
  input  logic [PINS-1:0]         dir_q,
  input  logic [PINS*FSEL_W-1:0]  func_q,
  input  logic [PINS-1:0]         slp_lvl_q,
  input  logic [PINS-1:0]         slp_dir_q,
  input  logic                    hold_q,
  input  logic [PINS-1:0]         out_q,
  output logic [PINS-1:0]         rdata
);
  logic [PINS-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_LEVEL:   rd_mux = level;
      A_DIR:     rd_mux = dir_q;
      A_FUNC_LO: rd_mux = func_q[0 +: PINS];
      A_FUNC_HI: rd_mux = func_q[PINS +: PINS];
      A_SLP_LVL: rd_mux = slp_lvl_q;
      A_SLP_DIR: rd_mux = slp_dir_q;
      A_CTRL:    rd_mux = {{(PINS-1){1'b0}}, hold_q};
      A_OUT:     rd_mux = out_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_pinmux_ctl.sv
module gpio_pinmux_ctl
  import gpm_pkg::*;
#(
  parameter logic [31:0] DIR_INV = 32'h0000_F000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        sleep_enter,
  input  logic        sleep_exit,
  input  logic [31:0] pad_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic [63:0] pin_func
);
  logic                   wr_en, rd_en;
  logic [PINS-1:0]        out_q, dir_q, slp_lvl_q, slp_dir_q, level;
  logic [PINS*FSEL_W-1:0] func_q;
  logic                   hold_q;

  assign wr_en = req && we;
  assign rd_en = req && !we;

  gpm_regfile #(.DIR_INV(DIR_INV)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
    .out_q(out_q), .dir_q(dir_q), .func_q(func_q),
    .slp_lvl_q(slp_lvl_q), .slp_dir_q(slp_dir_q), .hold_q(hold_q)
  );

  gpm_pinmap #(.DIR_INV(DIR_INV)) map_i (
    .out_q(out_q), .dir_q(dir_q), .func_q(func_q), .pad_in(pad_in),
    .hold_q(hold_q), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_func(pin_func), .level(level)
  );

  gpm_rdmux rd_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .level(level),
    .dir_q(dir_q), .func_q(func_q), .slp_lvl_q(slp_lvl_q),
    .slp_dir_q(slp_dir_q), .hold_q(hold_q), .out_q(out_q), .rdata(rdata)
  );
endmodule

// File: rtl/gpm_checker.sv
module gpm_checker #(
  parameter logic [31:0] DIR_INV = 32'h0000_F000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic [3:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        sleep_enter,
  input logic        sleep_exit,
  input logic [31:0] pin_out,
  input logic [31:0] pin_oe,
  input logic [63:0] pin_func,
  input logic [31:0] slp_lvl_q,
  input logic [31:0] slp_dir_q,
  input logic        hold_q
);
  a_r3_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == 4'd2 && !sleep_enter) |=>
      ((pin_out & $past(wdata)) == $past(wdata)) &&
      ((pin_out & ~$past(wdata)) == ($past(pin_out) & ~$past(wdata))));

  a_r4_clr_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == 4'd3 && !sleep_enter) |=>
      ((pin_out & $past(wdata)) == 32'h0) &&
      ((pin_out & ~$past(wdata)) == ($past(pin_out) & ~$past(wdata))));

  a_r2_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && (addr == 4'd2 || addr == 4'd3)) |=> rdata == 32'h0);

  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> $stable(rdata));

  a_r5_func_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == 4'd4) |=> pin_func[31:0] == $past(wdata));

  a_r7_sleep_applies: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> (pin_out == $past(slp_lvl_q)) &&
                    (pin_oe == ($past(slp_dir_q) ^ DIR_INV)));

  a_r8_exit_sets_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_exit |=> hold_q);

  a_r8_hold_only_falls_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(req && we && addr == 4'd8 && wdata[0]));
endmodule

bind gpio_pinmux_ctl gpm_checker #(.DIR_INV(DIR_INV)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
  .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func),
  .slp_lvl_q(slp_lvl_q), .slp_dir_q(slp_dir_q), .hold_q(hold_q)
);

// File: tb/gpio_pinmux_ctl_tb.sv
module gpio_pinmux_ctl_tb_top;
  localparam logic [31:0] INV = 32'h0000_F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic        sleep_enter = 1'b0, sleep_exit = 1'b0;
  logic [31:0] rdata, pin_out, pin_oe;
  logic [63:0] pin_func;

  always #5 clk = ~clk;

  gpio_pinmux_ctl #(.DIR_INV(INV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
    .pad_in(pad_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func)
  );

  // behavioural reference state
  bit [31:0] m_out, m_dir, m_slvl, m_sdir, m_rd;
  bit [1:0]  m_fn [32];
  bit        m_hold;
  int        vectors = 0, misses = 0;
  bit        done = 0;
  string     tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_dir = INV; m_slvl = 0; m_sdir = 0; m_rd = 0; m_hold = 1;
      for (int i = 0; i < 32; i++) m_fn[i] = 0;
    end else begin
      bit [31:0] nrd;
      bit        w;
      w = req && we;
      if (req && !we) begin
        nrd = 0;
        if (addr == 0) nrd = m_hold ? 32'h0 : pad_in;
        else if (addr == 1) nrd = m_dir;
        else if (addr == 4 || addr == 5)
          for (int i = 0; i < 16; i++) begin
            nrd[2*i]   = m_fn[(addr == 5 ? 16 : 0) + i][0];
            nrd[2*i+1] = m_fn[(addr == 5 ? 16 : 0) + i][1];
          end
        else if (addr == 6) nrd = m_slvl;
        else if (addr == 7) nrd = m_sdir;
        else if (addr == 8) nrd = {31'h0, m_hold};
        else if (addr == 9) nrd = m_out;
        m_rd = nrd;
      end
      if (sleep_enter) begin
        m_out = m_slvl; m_dir = m_sdir;
      end else if (w) begin
        for (int i = 0; i < 32; i++) begin
          if (addr == 2 && wdata[i]) m_out[i] = 1'b1;
          if (addr == 3 && wdata[i]) m_out[i] = 1'b0;
        end
        if (addr == 1) m_dir = wdata;
      end
      if (w && (addr == 4 || addr == 5))
        for (int i = 0; i < 16; i++)
          m_fn[(addr == 5 ? 16 : 0) + i] = {wdata[2*i+1], wdata[2*i]};
      if (w && addr == 6) m_slvl = wdata;
      if (w && addr == 7) m_sdir = wdata;
      if (sleep_exit) m_hold = 1;
      else if (w && addr == 8 && wdata[0]) m_hold = 0;
    end
  end

  task automatic cmp(input string t, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%h exp=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit [63:0] f;
    for (int i = 0; i < 32; i++) begin
      f[2*i] = m_fn[i][0]; f[2*i+1] = m_fn[i][1];
    end
    cmp("R3/R4/R7 pin_out", {32'h0, pin_out}, {32'h0, m_out});
    cmp("R6 pin_oe", {32'h0, pin_oe}, {32'h0, m_dir ^ INV});
    cmp("R5 pin_func", pin_func, f);
    cmp({tag, " rdata"}, {32'h0, rdata}, {32'h0, m_rd});
  endtask

  // one cycle: compare at the falling edge, then drive new inputs
  task automatic cyc(input bit r, input bit w, input bit [3:0] a,
                     input bit [31:0] d, input bit se = 0, input bit sx = 0);
    @(negedge clk);
    check_all();
    req = r; we = w; addr = a; wdata = d; sleep_enter = se; sleep_exit = sx;
  endtask

  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    cyc(1, 1, a, d);
  endtask

  task automatic rd(input bit [3:0] a);
    cyc(1, 0, a, 0);
    cyc(0, 0, 0, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    for (int a = 0; a < 10; a++) rd(4'(a));
    tag = "R2";
    wr(1, 32'hA5A5_0F0F); rd(1);
    rd(2); rd(3); rd(12); rd(15);
    tag = "R3";
    wr(2, 32'h8000_0011); rd(9);
    wr(2, 32'h0000_0000); rd(9);
    tag = "R4";
    wr(3, 32'h0000_0010); rd(9);
    wr(3, 32'hFFFF_FFFF); rd(9);
    tag = "R5";
    wr(4, 32'hC000_0003); wr(5, 32'h9000_0002); rd(4); rd(5);
    tag = "R6";
    wr(1, 32'h0000_0000); wr(1, 32'hFFFF_FFFF); rd(1);
    tag = "R7";
    wr(6, 32'h1234_5678); wr(7, 32'h0F0F_F0F0); wr(2, 32'hFFFF_FFFF);
    cyc(1, 1, 2, 32'hFFFF_FFFF, 1, 0);
    cyc(1, 1, 1, 32'h0000_0001, 1, 0);
    rd(9); rd(1);
    tag = "R8";
    pad_in = 32'hDEAD_BEEF;
    rd(8); wr(8, 32'h0000_0002); rd(8);
    wr(8, 32'h0000_0001); rd(8);
    cyc(0, 0, 0, 0, 0, 1); rd(8);
    wr(8, 1);
    cyc(1, 1, 8, 32'h1, 0, 1); rd(8);
    tag = "R9";
    rd(0); wr(8, 1); rd(0);
    pad_in = 32'h0BAD_F00D; rd(0);
    tag = "R2";
    for (int n = 0; n < 600; n++) begin
      pad_in = $urandom;
      cyc(($urandom % 4) != 0, $urandom % 2, 4'($urandom), $urandom,
          ($urandom % 16) == 0, ($urandom % 16) == 0);
    end
    cyc(0, 0, 0, 0);
    @(negedge clk);
    check_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule